// File: doc/BRIEF.md
# Answer-to-Reset Serial Streamer

This block sends a fixed 32-bit identification word out of a serial memory-card device when the card reader asks for it. The reader asks by pulsing the reset pin high while the device is selected (chip select low). The first bit appears on the serial data output as soon as the pulse is seen. Each later bit follows a falling edge of the serial clock. The block drives an output enable for the tri-state pad. While no stream is running, the pad is released.

The word is fixed when the design is built and comes only from a parameter. Software has no way to change it. The block does not start a stream while the access controller reports that a nonvolatile write is in progress. If chip select is raised during a stream, the stream ends at once and the block goes back to standby.

The serial clock, the reset pin and chip select are asynchronous to the system clock. Each passes through a synchroniser before any edge is detected. The outgoing bit stream has no valid/ready handshake. The reader paces it with the serial clock, so the block never applies back-pressure and never waits on the reader. The remaining pins are plain control and status signals.

Top module: `atr_streamer`

## Requirements
- R1: A stream starts only on a rising edge of `rst_pin`, after synchronisation, seen while the synchronised `cs_n` is low. A pulse seen while `cs_n` is high starts nothing.
- R2: A rising edge of `rst_pin` seen in a cycle where `wr_busy` is high starts nothing, and `sd_oe` stays 0.
- R3: A complete stream presents exactly `ATR_BITS` bits. Bit i of `ATR_PATTERN` is bit number i of the stream, so the stream goes out least significant bit first.
- R4: If the synchronised `cs_n` is high during a stream, `sd_oe` drops to 0 on the next clock. No further bits follow until a new start under R1.
- R5: Bit 0 is on `sd_out` with `sd_oe` high as soon as the stream starts. Each following bit replaces the previous one only after a falling edge of `scl`. With no such edge, `sd_out` holds its value.
- R6: While `sd_oe` is 0, `sd_out` is 0.
- R7: The falling `scl` edge that follows the last bit releases the line (`sd_oe` = 0) and returns the block to idle. A later pulse under R1 starts a fresh stream from bit 0.
- R8: A rising edge of `rst_pin` during a stream is ignored. The stream goes on from the bit it had reached.
- R9: After system reset (`rst_n` low), `sd_oe` and `sd_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rst_pin | input | 1 | Card reset request pin, active high, asynchronous |
| scl | input | 1 | Serial clock from the reader, asynchronous |
| wr_busy | input | 1 | Nonvolatile write in progress, synchronous to `clk` |
| sd_out | output | 1 | Serial data bit for the pad |
| sd_oe | output | 1 | Pad output enable, 1 drives `sd_out` |

## Verification
The assertions check these on every cycle:
- a stream begins only after a reset edge seen with chip select low and the busy flag clear;
- chip select high ends a stream on the next clock;
- the data line is low whenever it is released;
- the presented bit holds between serial clock falls;
- no stream presents more than `ATR_BITS` bits.

Only the bench's scenarios can show that the bits carry the parameter's value in least-significant-first order. The same holds for three more behaviours: a retrigger mid-stream leaves the bit position unchanged, the line is released after the last bit, and a new request after an abort or a completed stream starts again from bit 0.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } atr_state_e;
endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= INIT;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{INIT}};
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= INIT;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/atr_shifter.sv
module atr_shifter #(
  parameter int                  ATR_BITS    = 32,
  parameter logic [ATR_BITS-1:0] ATR_PATTERN = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic advance,
  output logic bit_q,
  output logic last
);
  localparam int IDX_W = (ATR_BITS > 1) ? $clog2(ATR_BITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ATR_BITS - 1);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (load)    idx <= '0;
    else if (advance) idx <= idx + 1'b1;
  end

  assign bit_q = ATR_PATTERN[idx];
  assign last  = (idx == LAST_IDX);
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       cs_hi,
  input  logic       scl_fall,
  input  logic       last,
  output logic       load,
  output logic       advance,
  output atr_state_e state
);
  atr_state_e nxt;

  always_comb begin
    nxt     = state;
    load    = 1'b0;
    advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_req) begin
          nxt  = ST_SEND;
          load = 1'b1;
        end
      end
      ST_SEND: begin
        if (cs_hi) begin
          nxt = ST_IDLE;
        end else if (scl_fall) begin
          if (last) nxt     = ST_IDLE;
          else      advance = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/atr_streamer.sv
module atr_streamer
  import atr_pkg::*;
#(
  parameter int                  ATR_BITS    = 32,
  parameter logic [ATR_BITS-1:0] ATR_PATTERN = 32'h9613_C25A,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rst_pin,
  input  logic scl,
  input  logic wr_busy,
  output logic sd_out,
  output logic sd_oe
);
  logic       cs_lvl, cs_rise_unused, cs_fall_unused;
  logic       rp_lvl, rst_rise, rp_fall_unused;
  logic       scl_lvl, scl_rise_unused, scl_fall;
  logic       start_req, load, advance, bit_q, last;
  atr_state_e state;

  atr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n),
    .level(cs_lvl), .rise(cs_rise_unused), .fall(cs_fall_unused)
  );

  atr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_rp_sync (
    .clk(clk), .rst_n(rst_n), .din(rst_pin),
    .level(rp_lvl), .rise(rst_rise), .fall(rp_fall_unused)
  );

  atr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .din(scl),
    .level(scl_lvl), .rise(scl_rise_unused), .fall(scl_fall)
  );

  assign start_req = rst_rise & ~cs_lvl & ~wr_busy;

  atr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cs_hi(cs_lvl),
    .scl_fall(scl_fall), .last(last), .load(load), .advance(advance),
    .state(state)
  );

  atr_shifter #(.ATR_BITS(ATR_BITS), .ATR_PATTERN(ATR_PATTERN)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .bit_q(bit_q), .last(last)
  );

  assign sd_oe  = (state == ST_SEND);
  assign sd_out = sd_oe & bit_q;
endmodule

// File: rtl/atr_streamer_chk.sv
module atr_streamer_chk #(
  parameter int ATR_BITS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic wr_busy,
  input logic cs_hi,
  input logic rst_rise,
  input logic scl_fall,
  input logic sd_out,
  input logic sd_oe
);
  localparam int CNT_W = $clog2(ATR_BITS + 1) + 1;
  logic [CNT_W-1:0] falls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        falls <= '0;
    else if (!sd_oe)   falls <= '0;
    else if (scl_fall) falls <= falls + 1'b1;
  end

  AST_START_ON_EDGE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> ($past(rst_rise) && !$past(cs_hi))); // R1

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> !$past(wr_busy)); // R2

  AST_BIT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> (falls < CNT_W'(ATR_BITS))); // R3

  AST_ABORT_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && cs_hi) |=> !sd_oe); // R4

  AST_HOLD_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && !cs_hi && !scl_fall) |=> (sd_oe && $stable(sd_out))); // R5 R8

  AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out); // R6

  always_comb begin
    if (!rst_n) begin
      AST_RESET_RELEASED: assert (!sd_oe); // R9
    end
  end
endmodule

bind atr_streamer atr_streamer_chk #(.ATR_BITS(ATR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_busy(wr_busy), .cs_hi(cs_lvl),
  .rst_rise(rst_rise), .scl_fall(scl_fall), .sd_out(sd_out), .sd_oe(sd_oe)
);

// File: tb/test_atr_streamer.sv
module test_atr_streamer;
  localparam int          NB  = 32;
  localparam logic [31:0] PAT = 32'hC35A_69E1;
  localparam int          HP  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic rst_pin = 1'b0;
  logic scl = 1'b0;
  logic wr_busy = 1'b0;
  logic sd_out, sd_oe;
  int   n_checks = 0;
  int   n_err = 0;
  int   cycles = 0;

  always #2 clk = ~clk;

  atr_streamer #(.ATR_BITS(NB), .ATR_PATTERN(PAT), .SYNC_STAGES(2)) i_atr_streamer (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rst_pin(rst_pin), .scl(scl),
    .wr_busy(wr_busy), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rst();
    rst_pin = 1'b1; wait_clk(6);
    rst_pin = 1'b0; wait_clk(HP);
  endtask

  task automatic scl_cycle();
    scl = 1'b1; wait_clk(HP);
    scl = 1'b0; wait_clk(HP);
  endtask

  // Reads bits first..NB-1 (bit first already on the line); returns them in place.
  task automatic collect(input int first, output logic [31:0] word, output int oe_bad);
    word = '0; oe_bad = 0;
    for (int i = first; i < NB; i++) begin
      if (i != first) scl_cycle();
      if (sd_oe !== 1'b1) oe_bad++;
      word[i] = sd_out;
    end
  endtask

  task automatic t_reset();
    wait_clk(3);
    check("R9 oe in reset", {31'b0, sd_oe}, 32'd0);
    check("R9 data in reset", {31'b0, sd_out}, 32'd0);
    rst_n = 1'b1; wait_clk(4);
    check("R9 oe after reset", {31'b0, sd_oe}, 32'd0);
  endtask

  task automatic t_full_stream(input string tag);
    logic [31:0] w; int bad;
    pulse_rst();
    check({tag, " R5 first bit with oe"}, {30'b0, sd_oe, sd_out}, {30'b0, 1'b1, PAT[0]});
    collect(0, w, bad);
    check({tag, " R3 pattern lsb first"}, w, PAT);
    check({tag, " R3 oe through stream"}, bad, 0);
    scl_cycle();
    check({tag, " R7 released after last"}, {31'b0, sd_oe}, 32'd0);
    check({tag, " R6 data low when released"}, {31'b0, sd_out}, 32'd0);
  endtask

  task automatic t_cs_high_no_start();
    cs_n = 1'b1; wait_clk(6);
    pulse_rst();
    check("R1 no start with cs high", {31'b0, sd_oe}, 32'd0);
    cs_n = 1'b0; wait_clk(6);
    check("R1 cs fall alone starts nothing", {31'b0, sd_oe}, 32'd0);
  endtask

  task automatic t_busy_block();
    wr_busy = 1'b1;
    pulse_rst();
    check("R2 no start while busy", {31'b0, sd_oe}, 32'd0);
    wr_busy = 1'b0; wait_clk(6);
    check("R2 still idle after busy clears", {31'b0, sd_oe}, 32'd0);
  endtask

  task automatic t_hold_no_fall();
    pulse_rst();
    scl = 1'b1; wait_clk(HP);
    check("R5 held across scl rise", {30'b0, sd_oe, sd_out}, {30'b0, 1'b1, PAT[0]});
    scl = 1'b0; wait_clk(HP);
    check("R5 next bit after fall", {30'b0, sd_oe, sd_out}, {30'b0, 1'b1, PAT[1]});
    cs_n = 1'b1; wait_clk(6);
    cs_n = 1'b0; wait_clk(6);
  endtask

  task automatic t_abort();
    for (int i = 0; i < 5; i++) begin
      if (i == 0) pulse_rst(); else scl_cycle();
    end
    check("R4 streaming before abort", {30'b0, sd_oe, sd_out}, {30'b0, 1'b1, PAT[4]});
    cs_n = 1'b1; wait_clk(6);
    check("R4 released on cs high", {31'b0, sd_oe}, 32'd0);
    cs_n = 1'b0; wait_clk(6);
    scl_cycle(); scl_cycle();
    check("R4 no bits after abort", {30'b0, sd_oe, sd_out}, 32'd0);
  endtask

  task automatic t_retrigger();
    logic [31:0] w; int bad;
    pulse_rst();
    scl_cycle(); scl_cycle(); scl_cycle();
    pulse_rst();
    check("R8 retrigger keeps bit 3", {30'b0, sd_oe, sd_out}, {30'b0, 1'b1, PAT[3]});
    collect(3, w, bad);
    check("R8 remaining bits continue", w & 32'hFFFF_FFF8, PAT & 32'hFFFF_FFF8);
    check("R8 oe through rest", bad, 0);
    scl_cycle();
    check("R7 released after retriggered stream", {31'b0, sd_oe}, 32'd0);
  endtask

  initial begin
    t_reset();
    cs_n = 1'b0; wait_clk(6);
    t_full_stream("first");
    t_cs_high_no_start();
    t_busy_block();
    t_hold_no_fall();
    t_abort();
    t_full_stream("after abort");
    t_retrigger();
    t_full_stream("repeat");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule